// File: doc/BRIEF.md
# PHY Channel Ownership Arbiter

This block decides which consumer may drive each of a small set of shared PHY channels. Every channel can be routed to one of two PHY indices. A requester sends a claim naming a channel and an index. The claim is granted only while nobody holds that channel. A granted claim rewrites that channel's routing field in a shared 32-bit select word, and it leaves the bits of every other channel as they were. A release frees the channel again.

Several requesters present one operation each per cycle. Within a cycle they are taken in a fixed order, lowest requester number first, and each one sees the effects of those ahead of it. The block keeps a running count of owned channels. While that count is non-zero it holds the shared clock request high.

Top module: `phy_route_arbiter`

## Requirements
- R1: After a synchronous reset, the select word is 0, no channel is owned, all owner bits are 0, the clock request is low, and every response code is 00 (none).
- R2: A claim on an unowned, legal channel returns code 01 (ok) in the cycle after the request. In that same cycle the channel's bit in `ch_owned` becomes 1 and its bit in `ch_owner` equals the claimed index.
- R3: A claim on an owned channel, for either index, returns code 10 (busy) and changes neither the select word nor the ownership state.
- R4: Channel 0 owns select bits 5:4. Index 0 writes them to 01 (value 0x10) and index 1 writes them to 11 (value 0x30).
- R5: Channel 2 owns select bit 31. Index 0 clears it and index 1 sets it.
- R6: Channel 1 owns no select bits. Claiming it changes only its ownership and owner bits.
- R7: A granted claim leaves every select bit outside the claimed channel's field unchanged. No bit outside 31 and 5:4 is ever set.
- R8: A claim with a channel number of 3 or more, or with an index of 2 or more, returns code 11 (invalid). The same code is returned for a release with a channel number of 3 or more. Neither case changes any state.
- R9: A release of a legal channel returns 01. It clears that channel's owned and owner bits and leaves the select word unchanged. A release of an unowned channel also returns 01 and changes nothing.
- R10: Requests in one cycle are applied in order, requester 0 first. When two claims target the same free channel, requester 0 gets 01 and requester 1 gets 10. When requester 0 releases a channel and requester 1 claims it in the same cycle, both get 01.
- R11: `clk_en` is high exactly while at least one channel is owned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 2 | Per-requester request strobe |
| req_release | input | 2 | Per-requester operation: 1 = release, 0 = claim |
| req_chan | input | 4 | Channel number, 2 bits per requester (requester r at bits 2r+1:2r) |
| req_idx | input | 4 | PHY index, 2 bits per requester |
| rsp_code | output | 4 | Response, 2 bits per requester: 00 none, 01 ok, 10 busy, 11 invalid |
| sel_reg | output | 32 | Shared routing select word |
| ch_owned | output | 3 | Per-channel owned flag |
| ch_owner | output | 3 | Per-channel index of the current owner (0 when unowned) |
| clk_en | output | 1 | Shared clock request |

## Verification
The hardest cases to reach are the ones where two requests in one cycle depend on each other. One is a release by requester 0 that frees a channel which requester 1 claims in the same cycle. The other is two claims racing for the same free channel. The stimulus table places both on purpose. It first drives ownership into a known state across all three channels. It then fires these paired requests and checks both response codes together with the select word. It also reuses a channel that was released with its routing bits left in place, which shows that a new claim clears the old field before setting the new one.

// File: rtl/phy_route_pkg.sv
package phy_route_pkg;

    localparam int SEL_W = 32;

    // Union of all routing fields; no other select bit may ever be set.
    localparam logic [SEL_W-1:0] ROUTE_ALL = 32'h8000_0030;

    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_OK   = 2'd1,
        RSP_BUSY = 2'd2,
        RSP_BAD  = 2'd3
    } rsp_e;

    typedef struct packed {
        logic live;   // request present
        logic drop;   // 1 = release, 0 = claim
        logic legal;  // channel / index in range
    } req_kind_t;

    function automatic logic [SEL_W-1:0] route_mask(input int ch);
        case (ch)
            0:       return 32'h0000_0030;
            2:       return 32'h8000_0000;
            default: return '0;
        endcase
    endfunction

    function automatic logic [SEL_W-1:0] route_value(input int ch, input logic idx);
        case (ch)
            0:       return idx ? 32'h0000_0030 : 32'h0000_0010;
            2:       return idx ? 32'h8000_0000 : 32'h0000_0000;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/phy_route_decode.sv
module phy_route_decode
    import phy_route_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CH_W   = 2,
    parameter int IDX_W  = 2
) (
    input  logic             valid,
    input  logic             release_op,
    input  logic [CH_W-1:0]  chan,
    input  logic [IDX_W-1:0] idx,
    output req_kind_t        kind,
    output logic             pick
);
    localparam logic [CH_W:0]  CH_LIM  = (CH_W+1)'(NUM_CH);
    localparam logic [IDX_W:0] IDX_LIM = (IDX_W+1)'(2);

    logic chan_ok;
    logic idx_ok;

    always_comb begin
        chan_ok    = ({1'b0, chan} < CH_LIM);
        idx_ok     = ({1'b0, idx} < IDX_LIM);
        kind.live  = valid;
        kind.drop  = release_op;
        kind.legal = release_op ? chan_ok : (chan_ok && idx_ok);
        pick       = idx[0];
    end
endmodule

// File: rtl/phy_route_core.sv
module phy_route_core
    import phy_route_pkg::*;
#(
    parameter int NUM_REQ = 2,
    parameter int NUM_CH  = 3,
    parameter int CH_W    = 2,
    parameter int CNT_W   = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  req_kind_t                 kind [NUM_REQ],
    input  logic [NUM_REQ*CH_W-1:0]   chan,
    input  logic [NUM_REQ-1:0]        pick,
    output rsp_e                      rsp_q [NUM_REQ],
    output logic [SEL_W-1:0]          sel_q,
    output logic [NUM_CH-1:0]         own_q,
    output logic [NUM_CH-1:0]         who_q,
    output logic [CNT_W-1:0]          n_take,
    output logic [CNT_W-1:0]          n_drop
);
    logic [SEL_W-1:0]  sel_n;
    logic [NUM_CH-1:0] own_n;
    logic [NUM_CH-1:0] who_n;
    rsp_e              rsp_n [NUM_REQ];
    logic              any_live;

    // Requests are applied in order; each sees the state left by those before it.
    always_comb begin
        own_n    = own_q;
        who_n    = who_q;
        sel_n    = sel_q;
        n_take   = '0;
        n_drop   = '0;
        any_live = 1'b0;
        for (int r = 0; r < NUM_REQ; r++) begin
            int ci;
            ci       = int'(chan[r*CH_W +: CH_W]);
            rsp_n[r] = RSP_NONE;
            if (kind[r].live) begin
                any_live = 1'b1;
                if (!kind[r].legal) begin
                    rsp_n[r] = RSP_BAD;
                end else if (kind[r].drop) begin
                    rsp_n[r] = RSP_OK;
                    if (own_n[ci]) begin
                        own_n[ci] = 1'b0;
                        who_n[ci] = 1'b0;
                        n_drop    = n_drop + CNT_W'(1);
                    end
                end else if (own_n[ci]) begin
                    rsp_n[r] = RSP_BUSY;
                end else begin
                    own_n[ci] = 1'b1;
                    who_n[ci] = pick[r];
                    sel_n     = (sel_n & ~route_mask(ci)) | route_value(ci, pick[r]);
                    n_take    = n_take + CNT_W'(1);
                    rsp_n[r]  = RSP_OK;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            own_q <= '0;
            who_q <= '0;
            for (int r = 0; r < NUM_REQ; r++) rsp_q[r] <= RSP_NONE;
        end else begin
            sel_q <= sel_n;
            own_q <= own_n;
            who_q <= who_n;
            for (int r = 0; r < NUM_REQ; r++) rsp_q[r] <= rsp_n[r];
        end
    end

    logic live_d;
    always_ff @(posedge clk) begin
        if (rst) live_d <= 1'b0;
        else     live_d <= any_live;
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sel_q == '0 && own_q == '0 && who_q == '0));

    assert_idle_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (!live_d && !$past(rst)) |-> ($stable(sel_q) && $stable(own_q) && $stable(who_q)));

    assert_sel_outside_masks_R7: assert property (@(posedge clk) disable iff (rst)
        (sel_q & ~ROUTE_ALL) == '0);

    assert_unowned_owner_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (who_q & ~own_q) == '0);
endmodule

// File: rtl/phy_route_clkcnt.sv
module phy_route_clkcnt #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] n_take,
    input  logic [CNT_W-1:0] n_drop,
    output logic             clk_en
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + n_take - n_drop;
    end

    assign clk_en = (cnt_q != '0);

    assert_no_underflow_R11: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, n_drop} <= {1'b0, cnt_q} + {1'b0, n_take}));
endmodule

// File: rtl/phy_route_arbiter.sv
module phy_route_arbiter
    import phy_route_pkg::*;
#(
    parameter int NUM_REQ = 2,
    parameter int NUM_CH  = 3,
    parameter int CH_W    = 2,
    parameter int IDX_W   = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_REQ-1:0]         req_valid,
    input  logic [NUM_REQ-1:0]         req_release,
    input  logic [NUM_REQ*CH_W-1:0]    req_chan,
    input  logic [NUM_REQ*IDX_W-1:0]   req_idx,
    output logic [NUM_REQ*2-1:0]       rsp_code,
    output logic [SEL_W-1:0]           sel_reg,
    output logic [NUM_CH-1:0]          ch_owned,
    output logic [NUM_CH-1:0]          ch_owner,
    output logic                       clk_en
);
    localparam int CNT_W = $clog2(NUM_CH + 1);

    req_kind_t          kind [NUM_REQ];
    logic [NUM_REQ-1:0] pick;
    rsp_e               rsp_q [NUM_REQ];
    logic [CNT_W-1:0]   n_take;
    logic [CNT_W-1:0]   n_drop;

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
        phy_route_decode #(
            .NUM_CH (NUM_CH),
            .CH_W   (CH_W),
            .IDX_W  (IDX_W)
        ) u_dec (
            .valid      (req_valid[r]),
            .release_op (req_release[r]),
            .chan       (req_chan[r*CH_W +: CH_W]),
            .idx        (req_idx[r*IDX_W +: IDX_W]),
            .kind       (kind[r]),
            .pick       (pick[r])
        );
        assign rsp_code[r*2 +: 2] = rsp_q[r];
    end

    phy_route_core #(
        .NUM_REQ (NUM_REQ),
        .NUM_CH  (NUM_CH),
        .CH_W    (CH_W),
        .CNT_W   (CNT_W)
    ) u_core (
        .clk    (clk),
        .rst    (rst),
        .kind   (kind),
        .chan   (req_chan),
        .pick   (pick),
        .rsp_q  (rsp_q),
        .sel_q  (sel_reg),
        .own_q  (ch_owned),
        .who_q  (ch_owner),
        .n_take (n_take),
        .n_drop (n_drop)
    );

    phy_route_clkcnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .n_take (n_take),
        .n_drop (n_drop),
        .clk_en (clk_en)
    );

    assert_clk_tracks_owners_R11: assert property (@(posedge clk) disable iff (rst)
        clk_en == (ch_owned != '0));

    assert_first_requester_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid[0] && !req_release[0] && req_chan[CH_W-1:0] < CH_W'(NUM_CH)
         && req_idx[IDX_W-1:1] == '0 && !ch_owned[req_chan[CH_W-1:0]])
        |=> (rsp_q[0] == RSP_OK));
endmodule

// File: tb/phy_route_arbiter_bench.sv
module phy_route_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  req_valid, req_release;
    logic [3:0]  req_chan, req_idx;
    logic [3:0]  rsp_code;
    logic [31:0] sel_reg;
    logic [2:0]  ch_owned, ch_owner;
    logic        clk_en;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    phy_route_arbiter u_phy_route_arbiter (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_release(req_release),
        .req_chan(req_chan), .req_idx(req_idx),
        .rsp_code(rsp_code), .sel_reg(sel_reg),
        .ch_owned(ch_owned), .ch_owner(ch_owner), .clk_en(clk_en)
    );

    // {valid, release, chan{r1,r0}, idx{r1,r0}, rsp{r1,r0}, sel, owned, owner, clk_en}
    localparam int NV = 15;
    localparam logic [54:0] VEC [NV] = '{
        {2'b01, 2'b00, 4'b0000, 4'b0001, 4'b0001, 32'h0000_0030, 3'b001, 3'b001, 1'b1},
        {2'b10, 2'b00, 4'b0000, 4'b0000, 4'b1000, 32'h0000_0030, 3'b001, 3'b001, 1'b1},
        {2'b01, 2'b00, 4'b0010, 4'b0001, 4'b0001, 32'h8000_0030, 3'b101, 3'b101, 1'b1},
        {2'b10, 2'b00, 4'b0100, 4'b0000, 4'b0100, 32'h8000_0030, 3'b111, 3'b101, 1'b1},
        {2'b01, 2'b01, 4'b0000, 4'b0000, 4'b0001, 32'h8000_0030, 3'b110, 3'b100, 1'b1},
        {2'b01, 2'b00, 4'b0000, 4'b0000, 4'b0001, 32'h8000_0010, 3'b111, 3'b100, 1'b1},
        {2'b11, 2'b00, 4'b1011, 4'b1000, 4'b1111, 32'h8000_0010, 3'b111, 3'b100, 1'b1},
        {2'b11, 2'b01, 4'b1010, 4'b0000, 4'b0101, 32'h0000_0010, 3'b111, 3'b000, 1'b1},
        {2'b11, 2'b11, 4'b0100, 4'b0000, 4'b0101, 32'h0000_0010, 3'b100, 3'b000, 1'b1},
        {2'b01, 2'b01, 4'b0010, 4'b0000, 4'b0001, 32'h0000_0010, 3'b000, 3'b000, 1'b0},
        {2'b01, 2'b01, 4'b0001, 4'b0000, 4'b0001, 32'h0000_0010, 3'b000, 3'b000, 1'b0},
        {2'b11, 2'b00, 4'b0101, 4'b0001, 4'b1001, 32'h0000_0010, 3'b010, 3'b010, 1'b1},
        {2'b10, 2'b00, 4'b0000, 4'b0100, 4'b0100, 32'h0000_0030, 3'b011, 3'b011, 1'b1},
        {2'b00, 2'b00, 4'b0000, 4'b0000, 4'b0000, 32'h0000_0030, 3'b011, 3'b011, 1'b1},
        {2'b01, 2'b01, 4'b0011, 4'b0000, 4'b0011, 32'h0000_0030, 3'b011, 3'b011, 1'b1}
    };
    localparam string TAG [NV] = '{
        "R2 R4 R11", "R3", "R5 R7", "R6", "R9", "R4 R7", "R8", "R10 R5",
        "R9", "R9 R11", "R9", "R10 R6", "R4 R7", "R3", "R8"
    };

    task automatic check(input string req, input logic [42:0] act, input logic [42:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [42:0] observe();
        return {rsp_code, sel_reg, ch_owned, ch_owner, clk_en};
    endfunction

    task automatic idle();
        req_valid = '0; req_release = '0; req_chan = '0; req_idx = '0;
    endtask

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state", observe(), 43'd0);

        for (int i = 0; i < NV; i++) begin
            {req_valid, req_release, req_chan, req_idx} = VEC[i][54:43];
            @(posedge clk);
            #1 idle();
            @(negedge clk);
            check(TAG[i], observe(), VEC[i][42:0]);
        end

        // Reset while channels are held clears everything (R1)
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", observe(), 43'd0);

        // Index 1 on channel 0 after reset, then busy from the other requester (R3)
        {req_valid, req_release, req_chan, req_idx} = {2'b01, 2'b00, 4'b0000, 4'b0001};
        @(posedge clk); #1 idle(); @(negedge clk);
        {req_valid, req_release, req_chan, req_idx} = {2'b10, 2'b00, 4'b0000, 4'b0100};
        @(posedge clk); #1 idle(); @(negedge clk);
        check("R3 busy index1 on held channel", observe(),
              {4'b1000, 32'h0000_0030, 3'b001, 3'b001, 1'b1});

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule